// File: doc/BRIEF.md
# Non-Volatile Write Error Status Tracker

This block collects the failure reports of a non-volatile memory write engine and holds them as sticky flags that software reads over a small register bus. The write engine reports three kinds of failure as one-cycle pulses: an erase that could not complete, a byte program that could not complete, and a program failure during the page swap of the emulated-EEPROM region. The engine also presents each byte program request to the block before issuing it. On the main array, the block refuses a request that would turn a stored 0 back into a 1. It records that refusal in the same flag that reports a swap-phase failure.

A master error flag in a control/status byte summarises the detail flags. Software writing 0 to the master flag is the only way to clear the master flag and all the detail flags. A failure event that lands in the same cycle as that write is kept. The block also decodes a two-bit status code for every sector from the master error flag and the engine's busy and suspend indications. When a swap-phase failure occurs, it signals the engine to stop before the erase phase.

Top module: `nvm_err_tracker`

## Requirements
- R1: After reset, reading either register (address 0 control byte, address 1 error byte) returns 00h while the busy and suspend inputs are low, and `abort_erase_o` is 0.
- R2: The error byte places the erase flag at bit 7, the program flag at bit 6 and the swap flag at bit 5. Bits 4:0 always read 0. Bus writes to address 1 change nothing.
- R3: An `erase_fail_i` pulse sets the erase flag and the master error flag from the next cycle on.
- R4: A `prog_fail_i` pulse that is not masked by R5 sets the program flag and the master error flag from the next cycle on.
- R5: A program request to the main array (`prog_region_i`=0) with `prog_protect_i`=0, where `(~prog_old_i & prog_new_i)` is nonzero, is refused combinationally (`prog_grant_o`=0). The swap flag and the master flag are set on the next cycle, and a `prog_fail_i` in that same cycle is ignored.
- R6: A request with `prog_protect_i`=1, or to the emulated-EEPROM region (`prog_region_i`=1), is never refused by the 0-to-1 check and never sets the swap flag. `prog_grant_o` equals `prog_req_i` for it.
- R7: A `swap_fail_i` pulse sets the swap flag and the master flag. It also drives `abort_erase_o` high for exactly the following cycle.
- R8: A bus write to address 0 with data bit 0 equal to 0 clears the master flag and all three detail flags. A write with bit 0 equal to 1 has no effect.
- R9: A failure pulse in the same cycle as the R8 clear wins. Its own flag and the master flag are 1 afterwards, and the other detail flags are cleared.
- R10: For each sector n, code bits [2n+1:2n] of `sector_code_o` are 0 when `sector_mark_i[n]` is 0. Otherwise they are 3 if the master flag is set, else 2 if `main_busy_i` is set, else 1 if `eep_busy_i` is 0 and `suspend_i` is 1, else 0.
- R11: The control byte shows the master flag at bit 0, `main_busy_i` at bit 1, `eep_busy_i` at bit 2 and `suspend_i` at bit 3, with bits 7:4 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| erase_fail_i | input | 1 | Erase failure pulse from the write engine |
| prog_fail_i | input | 1 | Byte program failure pulse |
| swap_fail_i | input | 1 | Program failure during EEPROM page swap |
| prog_req_i | input | 1 | Byte program request presented for checking |
| prog_region_i | input | 1 | Target region: 0 main array, 1 emulated EEPROM |
| prog_protect_i | input | 1 | Request targets the protection bits |
| prog_old_i | input | DATA_W | Byte currently stored at the target |
| prog_new_i | input | DATA_W | Byte to be programmed |
| prog_grant_o | output | 1 | Request may proceed |
| abort_erase_o | output | 1 | Skip erase phase after a swap failure |
| main_busy_i | input | 1 | Main-array write in progress |
| eep_busy_i | input | 1 | EEPROM write in progress |
| suspend_i | input | 1 | Sector erase suspended |
| sector_mark_i | input | N_SECTORS | Sectors touched by the current or failed operation |
| sector_code_o | output | 2*N_SECTORS | Per-sector status codes |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | Access is a write |
| bus_addr_i | input | 1 | 0 control byte, 1 error byte |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |

## Verification
On every cycle, the assertions check the register-level relations. A failure pulse is followed by its flag, and a refused main-array request is followed by the swap flag. A clear with no event empties the flags, and a swap failure is followed by the abort pulse. A set detail flag implies the master flag, and a marked sector reports an error code while the master flag is set. Only the bench's scenarios show the bus-visible side. They cover the bit positions in both bytes, the refusal of specific byte pairs, a clear and an event colliding in one cycle, writes that must change nothing, and the full priority ladder of the sector decode.

// File: rtl/nvm_err_pkg.sv
package nvm_err_pkg;

  localparam int REG_W      = 8;
  localparam int MAX_DATA_W = 64;

  // error byte bit positions (decoded by software)
  localparam int EB_ERASE = 7;
  localparam int EB_PROG  = 6;
  localparam int EB_SWAP  = 5;

  // control byte bit positions
  localparam int CB_MASTER = 0;
  localparam int CB_MBUSY  = 1;
  localparam int CB_EBUSY  = 2;
  localparam int CB_SUSP   = 3;

  typedef enum logic [1:0] {
    SEC_NONE = 2'd0,
    SEC_SUSP = 2'd1,
    SEC_BUSY = 2'd2,
    SEC_ERR  = 2'd3
  } sec_code_e;

  typedef enum logic {
    ADDR_CTL = 1'b0,
    ADDR_ERR = 1'b1
  } reg_addr_e;

  typedef enum logic {
    RGN_MAIN = 1'b0,
    RGN_EEP  = 1'b1
  } region_e;

  typedef struct packed {
    logic erase;
    logic prog;
    logic swap;
  } err_flags_t;

  // true when a program would need a cell to go from 0 back to 1
  function automatic logic needs_zero_to_one(input logic [MAX_DATA_W-1:0] stored,
                                              input logic [MAX_DATA_W-1:0] wanted);
    return |(~stored & wanted);
  endfunction

  // priority ladder for one sector's status code
  function automatic sec_code_e sector_meaning(input logic master, input logic mbusy,
                                               input logic ebusy, input logic susp);
    if (master)             return SEC_ERR;
    else if (mbusy)         return SEC_BUSY;
    else if (!ebusy && susp) return SEC_SUSP;
    else                    return SEC_NONE;
  endfunction

endpackage

// File: rtl/nvm_overwrite_chk.sv
module nvm_overwrite_chk
  import nvm_err_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              req_i,
  input  logic              region_i,
  input  logic              protect_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic              prog_fail_i,
  output logic              grant_o,
  output logic              refuse_o,
  output logic              prog_fail_o
);

  localparam int PAD_W = MAX_DATA_W - DATA_W;

  logic [MAX_DATA_W-1:0] old_ext;
  logic [MAX_DATA_W-1:0] new_ext;
  logic                  checked;

  generate
    if (PAD_W > 0) begin : g_pad
      assign old_ext = {{PAD_W{1'b1}}, old_i};
      assign new_ext = {{PAD_W{1'b0}}, new_i};
    end else begin : g_nopad
      assign old_ext = old_i;
      assign new_ext = new_i;
    end
  endgenerate

  // only main-array data bytes are subject to the 0-to-1 check
  assign checked     = req_i && (region_i == RGN_MAIN) && !protect_i;
  assign refuse_o    = checked && needs_zero_to_one(old_ext, new_ext);
  assign grant_o     = req_i && !refuse_o;
  // a refused write was never issued, so no program failure stands for it
  assign prog_fail_o = prog_fail_i && !refuse_o;

endmodule

// File: rtl/nvm_err_flags.sv
module nvm_err_flags
  import nvm_err_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_erase_i,
  input  logic       set_prog_i,
  input  logic       set_swap_i,
  input  logic       swap_fail_i,
  input  logic       clr_req_i,
  output err_flags_t flags_o,
  output logic       master_o,
  output logic       abort_o
);

  err_flags_t flags_q, flags_d;
  logic       master_q, master_d;
  logic       any_set;
  logic       abort_q;

  assign any_set = set_erase_i | set_prog_i | set_swap_i;

  always_comb begin
    flags_d  = flags_q;
    master_d = master_q;
    if (clr_req_i) begin
      flags_d  = '0;
      master_d = 1'b0;
    end
    // hardware events win over a same-cycle clear
    if (set_erase_i) flags_d.erase = 1'b1;
    if (set_prog_i)  flags_d.prog  = 1'b1;
    if (set_swap_i)  flags_d.swap  = 1'b1;
    if (any_set)     master_d      = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= '0;
      master_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      flags_q  <= flags_d;
      master_q <= master_d;
      abort_q  <= swap_fail_i;
    end
  end

  assign flags_o  = flags_q;
  assign master_o = master_q;
  assign abort_o  = abort_q;

  a_r3_erase_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    set_erase_i |=> (flags_q.erase && master_q));
  a_r4_prog_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    set_prog_i |=> (flags_q.prog && master_q));
  a_r7_abort_follows: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fail_i |=> (abort_q && flags_q.swap));
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req_i && !any_set) |=> (!master_q && flags_q == '0));
  a_r8_master_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != '0) |-> master_q);
  a_r9_master_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (master_q && !clr_req_i) |=> master_q);

endmodule

// File: rtl/nvm_sector_decode.sv
module nvm_sector_decode
  import nvm_err_pkg::*;
#(
  parameter int N_SECTORS = 4
) (
  input  logic                   master_i,
  input  logic                   mbusy_i,
  input  logic                   ebusy_i,
  input  logic                   susp_i,
  input  logic [N_SECTORS-1:0]   mark_i,
  output logic [2*N_SECTORS-1:0] code_o
);

  sec_code_e shared;

  assign shared = sector_meaning(master_i, mbusy_i, ebusy_i, susp_i);

  generate
    for (genvar s = 0; s < N_SECTORS; s++) begin : g_sec
      assign code_o[2*s +: 2] = mark_i[s] ? shared : SEC_NONE;
    end
  endgenerate

endmodule

// File: rtl/nvm_reg_port.sv
module nvm_reg_port
  import nvm_err_pkg::*;
(
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  err_flags_t       flags_i,
  input  logic             master_i,
  input  logic             mbusy_i,
  input  logic             ebusy_i,
  input  logic             susp_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             clr_req_o
);

  logic [REG_W-1:0] ctl_byte;
  logic [REG_W-1:0] err_byte;

  always_comb begin
    ctl_byte            = '0;
    ctl_byte[CB_MASTER] = master_i;
    ctl_byte[CB_MBUSY]  = mbusy_i;
    ctl_byte[CB_EBUSY]  = ebusy_i;
    ctl_byte[CB_SUSP]   = susp_i;
    err_byte            = '0;
    err_byte[EB_ERASE]  = flags_i.erase;
    err_byte[EB_PROG]   = flags_i.prog;
    err_byte[EB_SWAP]   = flags_i.swap;
  end

  assign rdata_o   = (addr_i == ADDR_ERR) ? err_byte : ctl_byte;
  // only writing 0 to the master bit has an effect; the error byte is read-only
  assign clr_req_o = sel_i && wr_i && (addr_i == ADDR_CTL) && !wdata_i[CB_MASTER];

endmodule

// File: rtl/nvm_err_tracker.sv
module nvm_err_tracker
  import nvm_err_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int N_SECTORS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   erase_fail_i,
  input  logic                   prog_fail_i,
  input  logic                   swap_fail_i,
  input  logic                   prog_req_i,
  input  logic                   prog_region_i,
  input  logic                   prog_protect_i,
  input  logic [DATA_W-1:0]      prog_old_i,
  input  logic [DATA_W-1:0]      prog_new_i,
  output logic                   prog_grant_o,
  output logic                   abort_erase_o,
  input  logic                   main_busy_i,
  input  logic                   eep_busy_i,
  input  logic                   suspend_i,
  input  logic [N_SECTORS-1:0]   sector_mark_i,
  output logic [2*N_SECTORS-1:0] sector_code_o,
  input  logic                   bus_sel_i,
  input  logic                   bus_wr_i,
  input  logic                   bus_addr_i,
  input  logic [7:0]             bus_wdata_i,
  output logic [7:0]             bus_rdata_o
);

  // named internal events
  logic       refuse_evt;
  logic       prog_fail_evt;
  logic       set_swap_evt;
  logic       clr_evt;
  err_flags_t flags;
  logic       master;

  nvm_overwrite_chk #(.DATA_W(DATA_W)) u_chk (
    .req_i       (prog_req_i),
    .region_i    (prog_region_i),
    .protect_i   (prog_protect_i),
    .old_i       (prog_old_i),
    .new_i       (prog_new_i),
    .prog_fail_i (prog_fail_i),
    .grant_o     (prog_grant_o),
    .refuse_o    (refuse_evt),
    .prog_fail_o (prog_fail_evt)
  );

  assign set_swap_evt = refuse_evt | swap_fail_i;

  nvm_err_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_erase_i (erase_fail_i),
    .set_prog_i  (prog_fail_evt),
    .set_swap_i  (set_swap_evt),
    .swap_fail_i (swap_fail_i),
    .clr_req_i   (clr_evt),
    .flags_o     (flags),
    .master_o    (master),
    .abort_o     (abort_erase_o)
  );

  nvm_reg_port u_regs (
    .sel_i     (bus_sel_i),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .flags_i   (flags),
    .master_i  (master),
    .mbusy_i   (main_busy_i),
    .ebusy_i   (eep_busy_i),
    .susp_i    (suspend_i),
    .rdata_o   (bus_rdata_o),
    .clr_req_o (clr_evt)
  );

  nvm_sector_decode #(.N_SECTORS(N_SECTORS)) u_sec (
    .master_i (master),
    .mbusy_i  (main_busy_i),
    .ebusy_i  (eep_busy_i),
    .susp_i   (suspend_i),
    .mark_i   (sector_mark_i),
    .code_o   (sector_code_o)
  );

  a_r5_refusal_flags_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req_i && !prog_region_i && !prog_protect_i && ((~prog_old_i & prog_new_i) != '0))
      |=> (flags.swap && master));
  a_r5_refusal_masks_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (refuse_evt && !flags.prog && !erase_fail_i && !clr_evt) |=> !flags.prog);
  a_r6_eep_never_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req_i && (prog_region_i || prog_protect_i)) |-> prog_grant_o);
  a_r10_marked_error: assert property (@(posedge clk) disable iff (!rst_n)
    (master && sector_mark_i[0]) |-> (sector_code_o[1:0] == SEC_ERR));

endmodule

// File: tb/nvm_err_tracker_test.sv
module nvm_err_tracker_test;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  typedef struct packed {
    logic       erase;
    logic       prog;
    logic       swap;
    logic       req;
    logic       region;
    logic       prot;
    logic [7:0] old_b;
    logic [7:0] new_b;
    logic       clr;
    logic       exp_grant;
    logic [7:0] exp_err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'hF0,8'hE0,1'b0,1'b1,8'h00}, // main ok
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h0F,8'h1F,1'b0,1'b0,8'h20}, // R5 refuse
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,1'b1,1'b0,8'h00}, // R8 clear
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,8'hFF,1'b0,1'b1,8'h00}, // R6 protect
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,8'hAA,8'hAA,1'b0,1'b1,8'h40}, // R4 prog fail
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,8'hC0}, // R3 erase
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h00,8'h00,1'b1,1'b0,8'h20}, // R9 clear+swap
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,1'b1,1'b0,8'h00}, // R8 clear
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,8'hFF,1'b0,1'b1,8'h00}, // R6 eeprom
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,8'h7F,8'h80,1'b0,1'b0,8'h20}, // R5 mask prog
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,1'b1,1'b0,8'h00}, // R8 clear
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,8'h00}  // idle
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic erase_fail = 0, prog_fail = 0, swap_fail = 0;
  logic prog_req = 0, prog_region = 0, prog_protect = 0;
  logic [7:0] prog_old = 0, prog_new = 0;
  logic prog_grant, abort_erase;
  logic main_busy = 0, eep_busy = 0, suspend = 0;
  logic [NS-1:0] sector_mark = '0;
  logic [2*NS-1:0] sector_code;
  logic bus_sel = 0, bus_wr = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_err_tracker #(.DATA_W(8), .N_SECTORS(NS)) uut (
    .clk(clk), .rst_n(rst_n),
    .erase_fail_i(erase_fail), .prog_fail_i(prog_fail), .swap_fail_i(swap_fail),
    .prog_req_i(prog_req), .prog_region_i(prog_region), .prog_protect_i(prog_protect),
    .prog_old_i(prog_old), .prog_new_i(prog_new), .prog_grant_o(prog_grant),
    .abort_erase_o(abort_erase), .main_busy_i(main_busy), .eep_busy_i(eep_busy),
    .suspend_i(suspend), .sector_mark_i(sector_mark), .sector_code_o(sector_code),
    .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    erase_fail = 0; prog_fail = 0; swap_fail = 0;
    prog_req = 0; prog_region = 0; prog_protect = 0;
    prog_old = 0; prog_new = 0;
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic read_reg(input logic a, output logic [7:0] v);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    v = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic write_ctl_cycle(input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = d;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic [7:0] ctl_exp;
    idle_inputs();
    repeat (2) @(negedge clk);
    // R1 reset state
    read_reg(0, v); check("R1 ctl byte", v, 8'h00);
    read_reg(1, v); check("R1 err byte", v, 8'h00);
    check("R1 abort", abort_erase, 1'b0);
    rst_n = 1;
    @(negedge clk);

    // vector table: R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < NV; i++) begin
      erase_fail = VEC[i].erase; prog_fail = VEC[i].prog; swap_fail = VEC[i].swap;
      prog_req = VEC[i].req; prog_region = VEC[i].region; prog_protect = VEC[i].prot;
      prog_old = VEC[i].old_b; prog_new = VEC[i].new_b;
      if (VEC[i].clr) begin
        bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'h00;
      end
      #1;
      check($sformatf("R5/R6 grant vec %0d", i), prog_grant, VEC[i].exp_grant);
      @(negedge clk);
      idle_inputs();
      read_reg(1, v);
      check($sformatf("R2 err byte vec %0d", i), v, VEC[i].exp_err);
      read_reg(0, v);
      ctl_exp = (VEC[i].exp_err != 0) ? 8'h01 : 8'h00;
      check($sformatf("R8 master vec %0d", i), v, ctl_exp);
    end

    // R7 abort pulse timing
    swap_fail = 1;
    @(negedge clk);
    swap_fail = 0;
    check("R7 abort high", abort_erase, 1'b1);
    read_reg(1, v); check("R7 swap flag", v, 8'h20);
    @(negedge clk);
    check("R7 abort single cycle", abort_erase, 1'b0);

    // R8 writing 1 has no effect
    write_ctl_cycle(8'hFF);
    read_reg(0, v); check("R8 write one keeps master", v, 8'h01);
    read_reg(1, v); check("R8 write one keeps flags", v, 8'h20);

    // R2 error byte writes ignored
    erase_fail = 1;
    @(negedge clk);
    erase_fail = 0;
    bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 8'h00;
    @(negedge clk);
    idle_inputs();
    read_reg(1, v); check("R2 write to err byte ignored", v, 8'hA0);
    read_reg(0, v); check("R2 master untouched", v, 8'h01);

    // R10 error priority, only marked sectors
    sector_mark = 4'b0101; main_busy = 1; suspend = 1;
    #1;
    check("R10 error code on marked", sector_code, 8'b00_11_00_11);
    write_ctl_cycle(8'h00);
    read_reg(1, v); check("R8 clear all flags", v, 8'h00);
    sector_mark = 4'b1111;
    #1;
    check("R10 busy code", sector_code, 8'hAA);
    // R11 control byte mirrors
    read_reg(0, v); check("R11 ctl mirrors busy/susp", v, 8'h0A);
    main_busy = 0; eep_busy = 0; suspend = 1;
    #1;
    check("R10 suspend code", sector_code, 8'h55);
    eep_busy = 1;
    #1;
    check("R10 eeprom busy hides suspend", sector_code, 8'h00);
    read_reg(0, v); check("R11 ctl mirror eep", v, 8'h0C);
    sector_mark = 4'b0010; eep_busy = 0;
    #1;
    check("R10 single sector", sector_code, 8'b00_00_01_00);

    // R9 clear colliding with erase event
    prog_fail = 1;
    @(negedge clk);
    idle_inputs();
    erase_fail = 1;
    bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'h00;
    @(negedge clk);
    idle_inputs();
    read_reg(1, v); check("R9 event wins over clear", v, 8'h80);
    read_reg(0, v); check("R9 master kept", v, 8'h09);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule